// File: doc/BRIEF.md
# Parallel Bus Master Transfer Engine

This block lets a processor run single transfers on an external asynchronous parallel bus. The processor reaches three registers through a small register port: a data register, an address register and a mode register. The mode register holds the transfer direction, the wait-state count, the pin assignment for each select pin, and a read-only busy flag. A write to the data register starts an external write. In read mode, any access to the data register starts an external read instead. Each transfer runs a fixed phase sequence on the bus pins: select, then data, then a strobe that wait states can lengthen, then a final hold cycle.

The busy flag is high for every cycle of a transfer except the last one. A processor that polls the flag can therefore start its next transfer in that last cycle, and the next transfer follows with no gap. The block drops, without any sign, every register access that arrives while busy is high. Each of the two select pins can instead act as a high address bit. In that role the pin follows the address register and takes no part in transfer timing.

Top module: `pmp_engine`

## Requirements
- R1: After reset every output is low and every register reads zero. This covers both select pins, both strobes, the data output enable and the address.
- R2: A write transfer is W+4 cycles long. Cycle 1 asserts each select pin in select mode with the address driven. From cycle 2 onward the data register is driven with output enable high. Cycles 3 to W+3 raise the write strobe. Cycle W+4 lowers the strobe and keeps select and data driven.
- R3: The wait count W is held in mode bits 7:4 and can be 0 to 15. It stretches the strobe phase to 1+W cycles.
- R4: The busy flag is mode bit 15. It is high in cycles 1 to W+3 of a transfer and low in cycle W+4 and whenever the bus is idle.
- R5: While busy is high, writes to the data, address and mode registers have no effect, and an access to the data register does not start a transfer.
- R6: A data-register access made in the last cycle of a transfer is accepted. The next transfer starts in the following cycle with no idle cycle between the two.
- R7: With mode bit 0 set, a write or a read of the data register (select 0) starts a read. Output enable stays low and the read strobe follows the strobe timing of R2. The bus input is sampled on the last strobe cycle, and register select 0 reads back the sampled value.
- R8: Setting mode bit 8+i turns select pin i into an address line. That pin then equals address register bit 14+i at all times.
- R9: When both select pins are address lines, a transfer keeps both strobes and output enable low. The busy timing is unchanged.
- R10: A read of the data register in write mode does not start a transfer.
- R11: The address register is select 1 and the mode register is select 2. The mode register reads back only bits 0, 7:4, 9:8 and 15. Select 3 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regSel | input | 2 | Register select: 0 data, 1 address, 2 mode |
| regWrEn | input | 1 | Register write enable |
| regRdEn | input | 1 | Register read enable (starts a read when read mode is set) |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Read-back of the selected register |
| pmAddr | output | 14 | External address bus |
| pmCs | output | 2 | Select pins, or high address bits when so configured |
| pmDataOut | output | 16 | Data driven onto the external bus |
| pmDataOe | output | 1 | Output enable for the data bus |
| pmDataIn | input | 16 | Data sampled from the external bus |
| pmWrStb | output | 1 | Active-high write strobe |
| pmRdStb | output | 1 | Active-high read strobe |

## Verification
A phase or wait counter that goes wrong shows at the pins within one cycle. A strobe appears early or late, output enable toggles at the wrong moment, or the busy flag falls in a cycle other than the last. The bench compares all of these against its own cycle model on every clock. A busy gate that is wrong lets a dropped register write through. The changed address or data then appears on the bus in the very next cycle or during the next transfer. A bad sample point in a read shows up as the wrong value when the data register is read back. The bench drives a different input value on every cycle, so such a fault cannot hide.

// File: rtl/pmp_pkg.sv
package pmp_pkg;
  localparam logic [1:0] SEL_DATA = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_MODE = 2'd2;

  typedef enum logic [2:0] {
    PH_IDLE, PH_SETUP, PH_DATA, PH_STROBE, PH_HOLD
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadData;
    logic loadAddr;
    logic loadMode;
    logic capture;
    logic csActive;
    logic driveData;
    logic strobe;
    logic xferRead;
    logic busy;
  } ctrlStrobes_t;
endpackage

// File: rtl/pmp_ctrl.sv
module pmp_ctrl
  import pmp_pkg::*;
#(
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic              readMode,
  input  logic [WAIT_W-1:0] waitCfg,
  output ctrlStrobes_t      ctl
);
  phase_t            phase;
  logic [WAIT_W-1:0] waitLeft;
  logic              isRead;
  logic              busyNow;
  logic              startXfer;
  logic              hitData;

  assign busyNow   = (phase != PH_IDLE) && (phase != PH_HOLD);
  assign hitData   = (regSel == SEL_DATA);
  assign startXfer = !busyNow && hitData && (regWrEn || (regRdEn && readMode));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      waitLeft <= '0;
      isRead   <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE, PH_HOLD: begin
          if (startXfer) begin
            phase  <= PH_SETUP;
            isRead <= readMode;
          end else begin
            phase  <= PH_IDLE;
          end
        end
        PH_SETUP: phase <= PH_DATA;
        PH_DATA: begin
          phase    <= PH_STROBE;
          waitLeft <= waitCfg;
        end
        PH_STROBE: begin
          if (waitLeft == '0) phase <= PH_HOLD;
          else                waitLeft <= waitLeft - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    ctl.busy      = busyNow;
    ctl.loadData  = !busyNow && hitData && regWrEn;
    ctl.loadAddr  = !busyNow && (regSel == SEL_ADDR) && regWrEn;
    ctl.loadMode  = !busyNow && (regSel == SEL_MODE) && regWrEn;
    ctl.capture   = (phase == PH_STROBE) && (waitLeft == '0) && isRead;
    ctl.csActive  = (phase != PH_IDLE);
    ctl.driveData = ((phase == PH_DATA) || (phase == PH_STROBE) || (phase == PH_HOLD)) && !isRead;
    ctl.strobe    = (phase == PH_STROBE);
    ctl.xferRead  = isRead;
  end
endmodule

// File: rtl/pmp_datapath.sv
module pmp_datapath
  import pmp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 14,
  parameter int CS_N   = 2,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      ctl,
  input  logic [1:0]        regSel,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic              readMode,
  output logic [WAIT_W-1:0] waitCfg,
  output logic [CS_N-1:0]   csAsAddr,
  output logic [ADDR_W-1:0] pmAddr,
  output logic [CS_N-1:0]   pmCs,
  output logic [DATA_W-1:0] pmDataOut,
  output logic              pmDataOe,
  input  logic [DATA_W-1:0] pmDataIn,
  output logic              pmWrStb,
  output logic              pmRdStb
);
  localparam int FULL_A   = ADDR_W + CS_N;
  localparam int WAIT_LSB = 4;
  localparam int CSA_LSB  = 8;
  localparam int BUSY_BIT = DATA_W - 1;

  logic [DATA_W-1:0] dataReg;
  logic [DATA_W-1:0] rdReg;
  logic [FULL_A-1:0] addrReg;
  logic [DATA_W-1:0] addrImg;
  logic [DATA_W-1:0] modeImg;
  logic              anyCs;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg  <= '0;
      rdReg    <= '0;
      addrReg  <= '0;
      readMode <= 1'b0;
      waitCfg  <= '0;
      csAsAddr <= '0;
    end else begin
      if (ctl.loadData) dataReg <= regWrData;
      if (ctl.loadAddr) addrReg <= regWrData[FULL_A-1:0];
      if (ctl.loadMode) begin
        readMode <= regWrData[0];
        waitCfg  <= regWrData[WAIT_LSB +: WAIT_W];
        csAsAddr <= regWrData[CSA_LSB +: CS_N];
      end
      if (ctl.capture) rdReg <= pmDataIn;
    end
  end

  assign anyCs  = ~&csAsAddr;
  assign pmAddr = addrReg[ADDR_W-1:0];

  for (genvar i = 0; i < CS_N; i++) begin : g_csPin
    assign pmCs[i] = csAsAddr[i] ? addrReg[ADDR_W+i] : ctl.csActive;
  end

  assign pmDataOut = dataReg;
  assign pmDataOe  = ctl.driveData && anyCs;
  assign pmWrStb   = ctl.strobe && !ctl.xferRead && anyCs;
  assign pmRdStb   = ctl.strobe && ctl.xferRead && anyCs;

  always_comb begin
    addrImg = '0;
    addrImg[FULL_A-1:0] = addrReg;
    modeImg = '0;
    modeImg[0] = readMode;
    modeImg[WAIT_LSB +: WAIT_W] = waitCfg;
    modeImg[CSA_LSB +: CS_N] = csAsAddr;
    modeImg[BUSY_BIT] = ctl.busy;
    case (regSel)
      SEL_DATA: regRdData = rdReg;
      SEL_ADDR: regRdData = addrImg;
      SEL_MODE: regRdData = modeImg;
      default:  regRdData = '0;
    endcase
  end
endmodule

// File: rtl/pmp_engine.sv
module pmp_engine
  import pmp_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int ADDR_W = 14,
  parameter int CS_N   = 2,
  parameter int WAIT_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        regSel,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  output logic [ADDR_W-1:0] pmAddr,
  output logic [CS_N-1:0]   pmCs,
  output logic [DATA_W-1:0] pmDataOut,
  output logic              pmDataOe,
  input  logic [DATA_W-1:0] pmDataIn,
  output logic              pmWrStb,
  output logic              pmRdStb
);
  ctrlStrobes_t      ctlBus;
  logic              readMode;
  logic [WAIT_W-1:0] waitCfg;
  logic [CS_N-1:0]   csAsAddr;
  logic              busyFlag;

  assign busyFlag = ctlBus.busy;

  pmp_ctrl #(.WAIT_W(WAIT_W)) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .regSel   (regSel),
    .regWrEn  (regWrEn),
    .regRdEn  (regRdEn),
    .readMode (readMode),
    .waitCfg  (waitCfg),
    .ctl      (ctlBus)
  );

  pmp_datapath #(
    .DATA_W (DATA_W),
    .ADDR_W (ADDR_W),
    .CS_N   (CS_N),
    .WAIT_W (WAIT_W)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctlBus),
    .regSel    (regSel),
    .regWrData (regWrData),
    .regRdData (regRdData),
    .readMode  (readMode),
    .waitCfg   (waitCfg),
    .csAsAddr  (csAsAddr),
    .pmAddr    (pmAddr),
    .pmCs      (pmCs),
    .pmDataOut (pmDataOut),
    .pmDataOe  (pmDataOe),
    .pmDataIn  (pmDataIn),
    .pmWrStb   (pmWrStb),
    .pmRdStb   (pmRdStb)
  );
endmodule

// File: rtl/pmp_engine_chk.sv
module pmp_engine_chk #(
  parameter int ADDR_W = 14,
  parameter int CS_N   = 2
) (
  input logic              clk,
  input logic              rstN,
  input logic              busy,
  input logic [CS_N-1:0]   csAsAddr,
  input logic [ADDR_W-1:0] pmAddr,
  input logic              pmDataOe,
  input logic              pmWrStb,
  input logic              pmRdStb
);
  AST_STB_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (pmWrStb || pmRdStb) |-> busy);                                   // R4
  AST_STB_FALL_LAST: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(pmWrStb) || $fell(pmRdStb)) |-> !busy);                     // R4
  AST_ADDR_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(pmAddr));                                        // R5
  AST_WR_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    pmWrStb |-> pmDataOe);                                            // R2
  AST_RD_NO_DRIVE: assert property (@(posedge clk) disable iff (!rstN)
    pmRdStb |-> !pmDataOe);                                           // R7
  AST_NO_CS_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    (&csAsAddr) |-> (!pmDataOe && !pmWrStb && !pmRdStb));             // R9
endmodule

bind pmp_engine pmp_engine_chk #(.ADDR_W(ADDR_W), .CS_N(CS_N)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busy     (busyFlag),
  .csAsAddr (csAsAddr),
  .pmAddr   (pmAddr),
  .pmDataOe (pmDataOe),
  .pmWrStb  (pmWrStb),
  .pmRdStb  (pmRdStb)
);

// File: tb/pmp_engine_tb.sv
`timescale 1ns/100ps
module pmp_engine_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [1:0]  regSel = 2'd2;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [13:0] pmAddr;
  logic [1:0]  pmCs;
  logic [15:0] pmDataOut;
  logic        pmDataOe;
  logic [15:0] pmDataIn = 16'h0101;
  logic        pmWrStb;
  logic        pmRdStb;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  pmp_engine dut_i (
    .clk(clk), .rstN(rstN), .regSel(regSel), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regWrData(regWrData), .regRdData(regRdData), .pmAddr(pmAddr), .pmCs(pmCs),
    .pmDataOut(pmDataOut), .pmDataOe(pmDataOe), .pmDataIn(pmDataIn),
    .pmWrStb(pmWrStb), .pmRdStb(pmRdStb)
  );

  // behavioural reference: position within the transfer
  int          mIdx = 0;
  int          mLen = 0;
  bit          mRead = 0;
  logic [15:0] mData = '0, mAddr = '0, mMode = '0, mRd = '0;

  function automatic bit mBusy();
    return (mIdx != 0) && (mIdx != mLen);
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mIdx = 0; mLen = 0; mRead = 0;
      mData = '0; mAddr = '0; mMode = '0; mRd = '0;
    end else begin
      bit b, st;
      b  = mBusy();
      st = !b && regSel == 2'd0 && (regWrEn || (regRdEn && mMode[0]));
      if (mIdx != 0 && mRead && mIdx == mLen - 1) mRd = pmDataIn;
      if (st) begin
        mIdx = 1; mLen = int'(mMode[7:4]) + 4; mRead = mMode[0];
      end else if (mIdx != 0) begin
        if (mIdx == mLen) mIdx = 0; else mIdx++;
      end
      if (!b && regWrEn) begin
        if (regSel == 2'd0) mData = regWrData;
        if (regSel == 2'd1) mAddr = regWrData;
        if (regSel == 2'd2) mMode = regWrData & 16'h03F1;
      end
    end
  end

  task automatic chk(bit ok, string tag, string what, logic [15:0] act, logic [15:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the edge
  always @(negedge clk) begin
    if (rstN && !done) begin
      bit anyCs, act;
      logic [1:0] eCs;
      logic [15:0] eRd;
      anyCs = !(mMode[8] && mMode[9]);
      act   = (mIdx != 0);
      eCs[0] = mMode[8] ? mAddr[14] : act;
      eCs[1] = mMode[9] ? mAddr[15] : act;
      chk(pmCs == eCs, "R8", "select pins", {14'd0, pmCs}, {14'd0, eCs});
      chk(pmAddr == mAddr[13:0], "R5", "address bus", {2'd0, pmAddr}, {2'd0, mAddr[13:0]});
      chk(pmDataOe == (act && !mRead && anyCs && mIdx >= 2), "R2", "output enable",
          {15'd0, pmDataOe}, {15'd0, act && !mRead && anyCs && mIdx >= 2});
      if (pmDataOe) chk(pmDataOut == mData, "R2", "data bus", pmDataOut, mData);
      chk(pmWrStb == (act && !mRead && anyCs && mIdx >= 3 && mIdx <= mLen - 1), "R3", "write strobe",
          {15'd0, pmWrStb}, {15'd0, act && !mRead && anyCs && mIdx >= 3 && mIdx <= mLen - 1});
      chk(pmRdStb == (act && mRead && anyCs && mIdx >= 3 && mIdx <= mLen - 1), "R7", "read strobe",
          {15'd0, pmRdStb}, {15'd0, act && mRead && anyCs && mIdx >= 3 && mIdx <= mLen - 1});
      case (regSel)
        2'd0: eRd = mRd;
        2'd1: eRd = mAddr;
        2'd2: eRd = mMode | {mBusy(), 15'd0};
        default: eRd = '0;
      endcase
      chk(regRdData == eRd, (regSel == 2'd2) ? "R4" : "R11", "register read", regRdData, eRd);
    end
  end

  task automatic step();
    @(posedge clk); #1;
    pmDataIn = pmDataIn * 16'd5 + 16'h1357;
  endtask

  task automatic regWr(logic [1:0] s, logic [15:0] d);
    regSel = s; regWrData = d; regWrEn = 1'b1;
    step();
    regWrEn = 1'b0;
  endtask

  task automatic regRd(logic [1:0] s);
    regSel = s; regRdEn = 1'b1;
    step();
    regRdEn = 1'b0;
  endtask

  task automatic waitIdle();
    while (mIdx != 0) step();
    regSel = 2'd2;
  endtask

  task automatic finishRun();
    done = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    nChecks++; nFails++;
    $display("FAIL R4 watchdog actual=hung expected=idle");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    regSel = 2'd0;
    // R1 reset state
    chk(pmCs == 2'b00 && !pmWrStb && !pmRdStb && !pmDataOe, "R1", "pins after reset",
        {12'd0, pmCs, pmWrStb, pmDataOe}, 16'h0000);
    chk(regRdData == 16'h0000 && pmAddr == '0, "R1", "regs after reset", regRdData, 16'h0000);
    step();

    // write with two wait states, back-to-back
    regWr(2'd1, 16'h1234);
    regWr(2'd2, 16'h0020);
    regWr(2'd0, 16'hA5C3);
    chk(pmCs == 2'b11 && !pmWrStb, "R2", "select in setup cycle", {14'd0, pmCs}, 16'h0003);
    regWr(2'd1, 16'h0F0F);        // ignored: busy (R5)
    regWr(2'd0, 16'h5555);        // ignored: busy (R5)
    regWr(2'd2, 16'h0001);        // ignored: busy (R5)
    step(); step();
    chk(mIdx == 6, "R6", "bench reached final cycle", mIdx[15:0], 16'd6);
    regWr(2'd0, 16'h3C3C);        // accepted in last cycle (R6)
    chk(pmCs == 2'b11 && mIdx == 1, "R6", "no gap between transfers", {14'd0, pmCs}, 16'h0003);
    waitIdle();
    step();
    chk(pmAddr == 14'h1234, "R5", "address unchanged by busy write", {2'd0, pmAddr}, 16'h1234);

    // wait count extremes
    regWr(2'd2, 16'h0000);
    regWr(2'd0, 16'h0F0F);
    waitIdle();
    regWr(2'd2, 16'h00F0);
    regWr(2'd0, 16'hF00F);
    waitIdle();
    step();

    // read transfers
    regWr(2'd2, 16'h0031);
    regRd(2'd0);
    waitIdle();
    regSel = 2'd0; step();
    chk(regRdData == mRd, "R7", "read data after read", regRdData, mRd);
    regWr(2'd0, 16'h0000);        // write also starts a read (R7)
    waitIdle();
    regSel = 2'd0; step();

    // R10: data read in write mode starts nothing
    regWr(2'd2, 16'h0010);
    regRd(2'd0);
    chk(pmCs == 2'b00 && mIdx == 0, "R10", "no transfer from read", {14'd0, pmCs}, 16'h0000);
    step();

    // R8: select 0 as address bit 14
    regWr(2'd1, 16'h4000);
    regWr(2'd2, 16'h0110);
    chk(pmCs == 2'b01, "R8", "pin 0 follows address", {14'd0, pmCs}, 16'h0001);
    regWr(2'd0, 16'h7777);
    waitIdle();
    regWr(2'd1, 16'h8000);
    regWr(2'd2, 16'h0210);
    chk(pmCs == 2'b10, "R8", "pin 1 follows address", {14'd0, pmCs}, 16'h0002);
    regWr(2'd0, 16'h1111);
    waitIdle();

    // R9: both pins address lines
    regWr(2'd2, 16'h0320);
    regWr(2'd0, 16'h2222);
    step(); step();
    chk(!pmWrStb && !pmDataOe, "R9", "no strobe without select", {14'd0, pmWrStb, pmDataOe}, 16'h0000);
    waitIdle();
    regWr(2'd2, 16'h0321);
    regRd(2'd0);
    waitIdle();
    regSel = 2'd3; step();
    chk(regRdData == 16'h0000, "R11", "unused select reads zero", regRdData, 16'h0000);
    step();
    finishRun();
  end
endmodule